// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block is a passive bus monitor for an asynchronous DRAM interface. It samples the four active-low control strobes (row strobe, column strobe, write enable, output enable) with a fast system clock. From the order in which those strobes change, it works out which kind of memory cycle the controller has just run. It drives no pins and stores no data. It is meant to sit next to a memory controller in a chip or in a test harness and report each completed cycle, so that protocol errors by the controller become visible.

Each strobe first passes through a synchronizer chain. An edge tracker then turns the sampled levels into assert and deassert events. A state machine resolves the order of those events into a cycle type. When a cycle ends, the block emits a one-clock valid pulse together with a one-hot cycle code. Separate one-clock flags mark a strobe sequence that breaks the protocol and edges that landed in the same sample, where their order cannot be told. A level output shows when the bus is idle.

Top module: `dram_cycle_classifier`

## Requirements
- R1: `bus_idle` is high exactly when both the row and column strobes are deasserted (high) after synchronization. It is low during every row-strobe-low period.
- R2: After reset, `cyc_valid`, `seq_err`, `edge_amb` and `cyc_kind` are all zero. Each report is a single-cycle `cyc_valid` pulse with exactly one bit of `cyc_kind` set. `cyc_kind` is zero whenever `cyc_valid` is low. The bit positions are: 0 read, 1 early write, 2 delayed write, 3 read-modify-write, 4 page access, 5 row-only refresh, 6 column-before-row refresh, 7 hidden refresh, 8 test-mode entry, 9 self refresh.
- R3: A column access inside a row-strobe-low period where write enable is asserted when the column strobe falls is reported as early write (bit 1). If write enable never falls during the access, it is reported as read (bit 0). The report comes when the column strobe rises, or when the row strobe rises while the column strobe is still low.
- R4: A column access where write enable falls after the column strobe has fallen is reported as read-modify-write (bit 3) if output enable was asserted at some point in that access before the write-enable fall. Otherwise it is reported as delayed write (bit 2).
- R5: Within one row-strobe-low period, the first column access is classified per R3/R4. Every later column access is reported as page access (bit 4).
- R6: A row-strobe-low period with no column strobe fall in it is reported as row-only refresh (bit 5) when the row strobe rises.
- R7: A column strobe fall while the row strobe is high, followed by a row strobe fall, is reported when the row strobe rises. With write enable deasserted at the row fall, it is column-before-row refresh (bit 6). With write enable asserted at the row fall, it is test-mode entry (bit 8), and `seq_err` pulses in the same cycle.
- R8: A column-before-row refresh whose row strobe stays low for at least `SELF_REF_CYCLES` clock samples is reported as self refresh (bit 9). One sample shorter gives bit 6.
- R9: After an access, if the row strobe rises and falls again while the column strobe stays low, the extra row-strobe pulse is reported as hidden refresh (bit 7) when it ends.
- R10: A column strobe that falls and rises again while the row strobe stays high pulses `seq_err` and produces no report. A column strobe that is still low after a column-before-row refresh may rise without error.
- R11: `edge_amb` pulses when the column strobe falls in the same sample as the row strobe or as write enable. Row fall is then taken as first, and a simultaneous write-enable fall counts as early write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe from the bus, active low, asynchronous |
| cas_n | input | 1 | Column strobe from the bus, active low, asynchronous |
| we_n | input | 1 | Write enable from the bus, active low, asynchronous |
| oe_n | input | 1 | Output enable from the bus, active low, asynchronous |
| cyc_valid | output | 1 | One-clock pulse when a cycle has been classified |
| cyc_kind | output | 10 | One-hot cycle type, valid with `cyc_valid` |
| seq_err | output | 1 | One-clock pulse on a protocol violation |
| edge_amb | output | 1 | One-clock pulse when edge order was unresolvable |
| bus_idle | output | 1 | Row and column strobes both deasserted |

## Verification
The bench builds the block with `SELF_REF_CYCLES` set to 40 and keeps the default two-stage synchronizer. With that setting, the self-refresh boundary is reached in a few dozen clocks, so both sides of it (40 and 39 samples of row-low time) are driven directly. Randomly timed refresh pulses fall on either side of the threshold. The strobe gaps are at least one clock, so every ordering the classifier depends on is exercised without ambiguity. The same-sample cases are then driven on purpose.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  localparam int NUM_STROBES = 4;
  localparam int SB_RAS = 0;
  localparam int SB_CAS = 1;
  localparam int SB_WE  = 2;
  localparam int SB_OE  = 3;

  localparam int KIND_W    = 10;
  localparam int KIND_IDXW = $clog2(KIND_W);

  localparam int K_READ   = 0;
  localparam int K_EWRITE = 1;
  localparam int K_DWRITE = 2;
  localparam int K_RMW    = 3;
  localparam int K_PAGE   = 4;
  localparam int K_ROWREF = 5;
  localparam int K_CBR    = 6;
  localparam int K_HIDDEN = 7;
  localparam int K_TEST   = 8;
  localparam int K_SELF   = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL_FIRST,
    ST_CBR,
    ST_HOLD,
    ST_HIDDEN
  } mon_state_e;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_n,
  output logic [WIDTH-1:0] act
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], pin_n[b]};
    end
    assign act[b] = ~chain[STAGES-1];
  end

endmodule

// File: rtl/edge_tracker.sv
module edge_tracker #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] asrt,
  output logic [WIDTH-1:0] dsrt
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign asrt[b] = lvl[b] & ~prev_q[b];
    assign dsrt[b] = ~lvl[b] & prev_q[b];
  end

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
  import dcc_pkg::*;
#(
  parameter int SELF_REF_CYCLES = 5000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_STROBES-1:0] lvl,
  input  logic [NUM_STROBES-1:0] asrt,
  input  logic [NUM_STROBES-1:0] dsrt,
  output logic                   valid_o,
  output logic [KIND_W-1:0]      kind_o,
  output logic                   err_o,
  output logic                   amb_o,
  output logic                   idle_o
);

  localparam int CNT_W = $clog2(SELF_REF_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(SELF_REF_CYCLES - 1);

  mon_state_e state_q, state_d;
  logic acc_act_q, acc_act_d;
  logic acc_early_q, acc_early_d;
  logic acc_wefell_q, acc_wefell_d;
  logic acc_rmw_q, acc_rmw_d;
  logic acc_oe_q, acc_oe_d;
  logic acc_any_q, acc_any_d;
  logic cbr_test_q, cbr_test_d;
  logic cbr_done_q, cbr_done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic                 rep, err, amb;
  logic [KIND_IDXW-1:0] rep_kind, acc_kind;

  logic l_cas, l_we, l_oe, a_ras, a_cas, a_we, d_ras, d_cas;
  logic unused_edges;
  assign l_cas = lvl[SB_CAS];
  assign l_we  = lvl[SB_WE];
  assign l_oe  = lvl[SB_OE];
  assign a_ras = asrt[SB_RAS];
  assign a_cas = asrt[SB_CAS];
  assign a_we  = asrt[SB_WE];
  assign d_ras = dsrt[SB_RAS];
  assign d_cas = dsrt[SB_CAS];
  assign unused_edges = ^{asrt[SB_OE], dsrt[SB_WE], dsrt[SB_OE]};

  always_comb begin
    if (acc_any_q)         acc_kind = KIND_IDXW'(K_PAGE);
    else if (acc_early_q)  acc_kind = KIND_IDXW'(K_EWRITE);
    else if (acc_wefell_q) acc_kind = acc_rmw_q ? KIND_IDXW'(K_RMW) : KIND_IDXW'(K_DWRITE);
    else                   acc_kind = KIND_IDXW'(K_READ);
  end

  always_comb begin
    state_d      = state_q;
    acc_act_d    = acc_act_q;
    acc_early_d  = acc_early_q;
    acc_wefell_d = acc_wefell_q;
    acc_rmw_d    = acc_rmw_q;
    acc_oe_d     = acc_oe_q;
    acc_any_d    = acc_any_q;
    cbr_test_d   = cbr_test_q;
    cbr_done_d   = cbr_done_q;
    cnt_d        = cnt_q;
    rep          = 1'b0;
    rep_kind     = '0;
    err          = 1'b0;
    amb          = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (a_ras) begin
          state_d   = ST_ROW;
          acc_any_d = 1'b0;
          acc_act_d = 1'b0;
          if (a_cas) begin
            amb          = 1'b1;
            acc_act_d    = 1'b1;
            acc_early_d  = l_we;
            acc_wefell_d = 1'b0;
            acc_rmw_d    = 1'b0;
            acc_oe_d     = l_oe;
          end
        end else if (a_cas) begin
          state_d    = ST_COL_FIRST;
          cbr_done_d = 1'b0;
        end
      end

      ST_ROW: begin
        if (acc_act_q && !acc_wefell_q && !acc_early_q) begin
          acc_oe_d = acc_oe_q | l_oe;
          if (a_we) begin
            acc_wefell_d = 1'b1;
            acc_rmw_d    = acc_oe_q | l_oe;
          end
        end
        if (d_ras) begin
          if (acc_act_q) begin
            rep      = 1'b1;
            rep_kind = acc_kind;
          end else if (!acc_any_q) begin
            rep      = 1'b1;
            rep_kind = KIND_IDXW'(K_ROWREF);
          end
          acc_act_d = 1'b0;
          state_d   = l_cas ? ST_HOLD : ST_IDLE;
        end else if (acc_act_q && d_cas) begin
          rep       = 1'b1;
          rep_kind  = acc_kind;
          acc_act_d = 1'b0;
          acc_any_d = 1'b1;
        end else if (!acc_act_q && a_cas) begin
          acc_act_d    = 1'b1;
          acc_early_d  = l_we;
          acc_wefell_d = 1'b0;
          acc_rmw_d    = 1'b0;
          acc_oe_d     = l_oe;
          amb          = a_we;
        end
      end

      ST_COL_FIRST: begin
        if (a_ras) begin
          if (d_cas) begin
            err     = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d    = ST_CBR;
            cbr_test_d = l_we;
            cnt_d      = '0;
          end
        end else if (d_cas) begin
          err     = ~cbr_done_q;
          state_d = ST_IDLE;
        end
      end

      ST_CBR: begin
        if (cnt_q != CNT_LIM) cnt_d = cnt_q + 1'b1;
        if (d_ras) begin
          rep        = 1'b1;
          err        = cbr_test_q;
          cbr_done_d = 1'b1;
          if (cbr_test_q)          rep_kind = KIND_IDXW'(K_TEST);
          else if (cnt_q >= CNT_LIM) rep_kind = KIND_IDXW'(K_SELF);
          else                     rep_kind = KIND_IDXW'(K_CBR);
          state_d = l_cas ? ST_COL_FIRST : ST_IDLE;
        end
      end

      ST_HOLD: begin
        if (a_ras)      state_d = ST_HIDDEN;
        else if (d_cas) state_d = ST_IDLE;
      end

      ST_HIDDEN: begin
        if (d_ras) begin
          rep      = 1'b1;
          rep_kind = KIND_IDXW'(K_HIDDEN);
          state_d  = l_cas ? ST_HOLD : ST_IDLE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      acc_act_q    <= 1'b0;
      acc_early_q  <= 1'b0;
      acc_wefell_q <= 1'b0;
      acc_rmw_q    <= 1'b0;
      acc_oe_q     <= 1'b0;
      acc_any_q    <= 1'b0;
      cbr_test_q   <= 1'b0;
      cbr_done_q   <= 1'b0;
      cnt_q        <= '0;
      valid_o      <= 1'b0;
      kind_o       <= '0;
      err_o        <= 1'b0;
      amb_o        <= 1'b0;
      idle_o       <= 1'b0;
    end else begin
      state_q      <= state_d;
      acc_act_q    <= acc_act_d;
      acc_early_q  <= acc_early_d;
      acc_wefell_q <= acc_wefell_d;
      acc_rmw_q    <= acc_rmw_d;
      acc_oe_q     <= acc_oe_d;
      acc_any_q    <= acc_any_d;
      cbr_test_q   <= cbr_test_d;
      cbr_done_q   <= cbr_done_d;
      cnt_q        <= cnt_d;
      valid_o      <= rep;
      kind_o       <= rep ? (KIND_W'(1) << rep_kind) : '0;
      err_o        <= err;
      amb_o        <= amb;
      idle_o       <= ~lvl[SB_RAS] & ~l_cas;
    end
  end

  AST_REPORT_AT_EDGE: assert property (@(posedge clk) disable iff (rst) valid_o |-> $past(d_ras | d_cas)); // R2
  AST_ERR_AT_RISE: assert property (@(posedge clk) disable iff (rst) err_o |-> $past(d_cas | d_ras)); // R10
  AST_AMB_SAME_SAMPLE: assert property (@(posedge clk) disable iff (rst) amb_o |-> $past(a_cas & (a_ras | a_we))); // R11
  AST_IDLE_NO_ROW: assert property (@(posedge clk) disable iff (rst) idle_o |-> !$past(lvl[SB_RAS])); // R1

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
  import dcc_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int SELF_REF_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  output logic              cyc_valid,
  output logic [KIND_W-1:0] cyc_kind,
  output logic              seq_err,
  output logic              edge_amb,
  output logic              bus_idle
);

  logic [NUM_STROBES-1:0] pins_n, lvl, asrt, dsrt;

  assign pins_n[SB_RAS] = ras_n;
  assign pins_n[SB_CAS] = cas_n;
  assign pins_n[SB_WE]  = we_n;
  assign pins_n[SB_OE]  = oe_n;

  strobe_sync #(
    .WIDTH (NUM_STROBES),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin_n(pins_n),
    .act  (lvl)
  );

  edge_tracker #(
    .WIDTH(NUM_STROBES)
  ) u_edges (
    .clk (clk),
    .rst (rst),
    .lvl (lvl),
    .asrt(asrt),
    .dsrt(dsrt)
  );

  cycle_fsm #(
    .SELF_REF_CYCLES(SELF_REF_CYCLES)
  ) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .lvl    (lvl),
    .asrt   (asrt),
    .dsrt   (dsrt),
    .valid_o(cyc_valid),
    .kind_o (cyc_kind),
    .err_o  (seq_err),
    .amb_o  (edge_amb),
    .idle_o (bus_idle)
  );

  AST_KIND_ONEHOT: assert property (@(posedge clk) disable iff (rst) cyc_valid |-> ($countones(cyc_kind) == 1)); // R2
  AST_KIND_QUIET: assert property (@(posedge clk) disable iff (rst) !cyc_valid |-> (cyc_kind == '0)); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) cyc_valid |=> !cyc_valid); // R2

endmodule

// File: tb/test_dram_cycle_classifier.sv
module test_dram_cycle_classifier;

  localparam int SELF_N = 40;
  localparam int KW     = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic          cyc_valid, seq_err, edge_amb, bus_idle;
  logic [KW-1:0] cyc_kind;

  int checks = 0, failures = 0;
  int v_cnt = 0, e_cnt = 0, a_cnt = 0;
  int v_base = 0, e_base = 0, a_base = 0;
  logic [KW-1:0] last_kind = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_cycle_classifier #(
    .SYNC_STAGES    (2),
    .SELF_REF_CYCLES(SELF_N)
  ) i_dram_cycle_classifier (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .cyc_valid(cyc_valid),
    .cyc_kind (cyc_kind),
    .seq_err  (seq_err),
    .edge_amb (edge_amb),
    .bus_idle (bus_idle)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (cyc_valid) begin
        v_cnt++;
        last_kind = cyc_kind;
      end
      if (seq_err)  e_cnt++;
      if (edge_amb) a_cnt++;
    end
  end

  function automatic logic [KW-1:0] kvec(int code);
    return KW'(1) << code;
  endfunction

  function automatic int row_kind(int n, int mode);
    if (n == 0) return 5;
    if (n > 1)  return 4;
    return mode;
  endfunction

  function automatic int cbr_kind(int len, bit tst);
    if (tst) return 8;
    if (len >= SELF_N) return 9;
    return 6;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(int ev, int ek, int ee, int ea, string req);
    hold(6);
    chk((v_cnt - v_base) == ev, req, "report count", v_cnt - v_base, ev);
    if (ev > 0) chk(last_kind == kvec(ek), req, "kind", int'(last_kind), int'(kvec(ek)));
    chk((e_cnt - e_base) == ee, req, "error count", e_cnt - e_base, ee);
    chk((a_cnt - a_base) == ea, req, "ambiguity count", a_cnt - a_base, ea);
    v_base = v_cnt; e_base = e_cnt; a_base = a_cnt;
  endtask

  task automatic sc_row(int n, int mode, int g, string req);
    ras_n = 1'b0;
    hold(3);
    chk(bus_idle == 1'b0, "R1", "idle during row", int'(bus_idle), 0);
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: begin oe_n = 1'b0; hold(1); cas_n = 1'b0; hold(g); cas_n = 1'b1; oe_n = 1'b1; hold(g); end
        1: begin we_n = 1'b0; hold(1); cas_n = 1'b0; hold(g); cas_n = 1'b1; hold(1); we_n = 1'b1; hold(g); end
        2: begin cas_n = 1'b0; hold(2); we_n = 1'b0; hold(g); cas_n = 1'b1; hold(1); we_n = 1'b1; hold(g); end
        default: begin
          cas_n = 1'b0; hold(1); oe_n = 1'b0; hold(2); oe_n = 1'b1; we_n = 1'b0; hold(g);
          cas_n = 1'b1; hold(1); we_n = 1'b1; hold(g);
        end
      endcase
    end
    ras_n = 1'b1;
    hold(g + 1);
    settle((n == 0) ? 1 : n, row_kind(n, mode), 0, 0, req);
  endtask

  task automatic sc_cbr(int len, bit tst, string req);
    cas_n = 1'b0; hold(2);
    we_n = tst ? 1'b0 : 1'b1; hold(1);
    ras_n = 1'b0; hold(len);
    ras_n = 1'b1; hold(2);
    cas_n = 1'b1; we_n = 1'b1; hold(2);
    settle(1, cbr_kind(len, tst), tst ? 1 : 0, 0, req);
  endtask

  task automatic sc_hidden(int g);
    oe_n = 1'b0; ras_n = 1'b0; hold(2);
    cas_n = 1'b0; hold(g);
    ras_n = 1'b1; hold(g + 1);
    ras_n = 1'b0; hold(g + 1);
    ras_n = 1'b1; hold(g);
    cas_n = 1'b1; oe_n = 1'b1; hold(2);
    settle(2, 7, 0, 0, "R9");
  endtask

  task automatic sc_stray(int g);
    cas_n = 1'b0; hold(g);
    cas_n = 1'b1; hold(2);
    settle(0, 0, 1, 0, "R10");
  endtask

  initial begin
    int sd;
    sd = $urandom(32'd4711);
    rst = 1'b1;
    hold(5);
    rst = 1'b0;
    // R2: reset state
    chk(cyc_valid == 1'b0, "R2", "valid after reset", int'(cyc_valid), 0);
    chk(cyc_kind == '0, "R2", "kind after reset", int'(cyc_kind), 0);
    chk(seq_err == 1'b0, "R2", "err after reset", int'(seq_err), 0);
    chk(edge_amb == 1'b0, "R2", "amb after reset", int'(edge_amb), 0);
    hold(4);
    chk(bus_idle == 1'b1, "R1", "idle at rest", int'(bus_idle), 1);

    sc_row(1, 0, 3, "R3");
    sc_row(1, 1, 3, "R3");
    sc_row(1, 2, 3, "R4");
    sc_row(1, 3, 3, "R4");
    sc_row(3, 0, 2, "R5");
    sc_row(2, 1, 2, "R5");
    sc_row(0, 0, 4, "R6");
    sc_cbr(10, 1'b0, "R7");
    sc_cbr(10, 1'b1, "R7");
    sc_cbr(SELF_N, 1'b0, "R8");
    sc_cbr(SELF_N - 1, 1'b0, "R8");
    sc_hidden(3);
    sc_stray(3);

    // R11: row and column strobes fall together
    oe_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; hold(3);
    cas_n = 1'b1; oe_n = 1'b1; hold(1);
    ras_n = 1'b1; hold(2);
    settle(1, 0, 0, 1, "R11");
    // R11: column strobe and write enable fall together
    ras_n = 1'b0; hold(2);
    cas_n = 1'b0; we_n = 1'b0; hold(2);
    cas_n = 1'b1; hold(1);
    we_n = 1'b1; ras_n = 1'b1; hold(2);
    settle(1, 1, 0, 1, "R11");

    for (int it = 0; it < 40; it++) begin
      int pick;
      pick = int'($urandom_range(0, 3));
      case (pick)
        0: sc_row(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(1, 4)), "R5");
        1: sc_cbr(int'($urandom_range(2, 60)), bit'($urandom_range(0, 1)), "R8");
        2: sc_hidden(int'($urandom_range(1, 4)));
        default: sc_stray(int'($urandom_range(1, 5)));
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule